// File: doc/BRIEF.md
# Sampled PI Regulator with Back-Calculation Anti-Windup

This block is a fixed-point proportional-integral regulator that runs one control update each time a sample strobe arrives. It subtracts a feedback sample from a reference sample to get the error. It advances an integral state by forward Euler and adds a proportional term. The sum is limited to a programmable window. The control value is registered and comes out one clock after the strobe, together with a one-cycle valid flag.

The stored integral already carries the integral gain and the sample interval, so each update adds `(ki*dt)*error` to it. When the unlimited output leaves the window and anti-windup is enabled, the integral is rewritten to `limit - kp*error`. The next update then starts from the limit and not from a wound-up value. With `ki` at zero the regulator is purely proportional. With the limits at the ends of the number range the window never binds, and anti-windup then has no effect.

All data ports use signed Q8.16: 24 bits, where an integer value v stands for v/65536. Every addition and subtraction saturates. Every product is the full signed product, shifted right by 16 arithmetically (rounding toward minus infinity), then saturated.

Top module: `pi_regulator`

## Requirements
- R1: While reset is asserted and after it is released, the integral state is 0, `ctl_out` is 0 and `ctl_vld` is 0.
- R2: `ctl_vld` is high in exactly the clock cycle after each cycle in which `smp_vld` is high, and low otherwise.
- R3: The error is the saturated difference `in_pos - in_neg`; with `ki = 0` the result is `kp*error`.
- R4: On each strobe the integral becomes `sat(I + (ki*dt)*error)`, and the output for that strobe uses this updated integral: `u = sat(kp*error + I_new)`.
- R5: The output is `lim_hi` when `u > lim_hi`, else `lim_lo` when `u < lim_lo`, else `u`; the upper bound is tested first.
- R6: With `aw_en = 1` and `u > lim_hi`, the integral is set to `sat(lim_hi - kp*error)`.
- R7: With `aw_en = 1` and `u < lim_lo`, the integral is set to `sat(lim_lo - kp*error)`.
- R8: With `aw_en = 0` the integral keeps the accumulated value even while the output is limited, so the output stays limited after the error falls to zero.
- R9: Results that exceed the Q8.16 range saturate to 0x7FFFFF (positive) or 0x800000 (negative). This covers the error, each product and each sum.
- R10: Cycles without a strobe change neither the integral nor `ctl_out`, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample strobe; one update per high cycle |
| in_pos | input | 24 | Reference sample, Q8.16 |
| in_neg | input | 24 | Feedback sample, Q8.16 |
| kp | input | 24 | Proportional gain, Q8.16 |
| ki | input | 24 | Integral gain, Q8.16 |
| dt | input | 24 | Sample interval, Q8.16 |
| lim_lo | input | 24 | Lower output limit, Q8.16 |
| lim_hi | input | 24 | Upper output limit, Q8.16 |
| aw_en | input | 1 | Anti-windup enable |
| ctl_out | output | 24 | Limited control value, Q8.16 |
| ctl_vld | output | 1 | One-cycle flag marking a new `ctl_out` |

## Verification
The assertions check the following on every cycle:
- the one-clock strobe-to-valid relation;
- that the output and the integral hold still between strobes;
- that a valid output lies inside the limits that applied at its strobe, when those limits are ordered;
- that an upper-limit event with anti-windup drives the output onto the limit.

Only the bench's scenarios show the exact arithmetic values. These are the back-calculated integral, which appears as the immediate recovery once the error returns to zero, and the persistent saturation without anti-windup. They also cover the saturation of the error and of the products at the ends of the Q8.16 range. A behavioural model compares every output cycle, including a long run of back-to-back strobes with varied gains and limits.

// File: rtl/pi_reg_pkg.sv
package pi_reg_pkg;
  localparam int unsigned Q_W = 24;
  localparam int unsigned Q_F = 16;

  typedef enum logic [1:0] {
    CLP_NONE = 2'd0,
    CLP_HI   = 2'd1,
    CLP_LO   = 2'd2
  } clp_e;
endpackage

// File: rtl/pi_rst_sync.sv
module pi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pi_satadd.sv
module pi_satadd #(
  parameter int unsigned W   = 24,
  parameter bit          SUB = 1'b0
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] ext_a, ext_b, raw;

  assign ext_a = {a[W-1], a};
  assign ext_b = {b[W-1], b};

  generate
    if (SUB) begin : g_sub
      assign raw = ext_a - ext_b;
    end else begin : g_add
      assign raw = ext_a + ext_b;
    end
  endgenerate

  always_comb begin
    if (raw[W] != raw[W-1]) y = raw[W] ? MINV : MAXV;
    else                    y = raw[W-1:0];
  end
endmodule

// File: rtl/pi_qmul.sv
module pi_qmul #(
  parameter int unsigned W = 24,
  parameter int unsigned F = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int unsigned PW = 2 * W;
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] full, shifted;
  logic                 fits;

  assign full    = PW'(a) * PW'(b);
  assign shifted = full >>> F;
  assign fits    = (&shifted[PW-1:W-1]) | ~(|shifted[PW-1:W-1]);

  always_comb begin
    if (fits) y = shifted[W-1:0];
    else      y = shifted[PW-1] ? MINV : MAXV;
  end
endmodule

// File: rtl/pi_clamp.sv
module pi_clamp
  import pi_reg_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic signed [W-1:0] u,
  input  logic signed [W-1:0] lo,
  input  logic signed [W-1:0] hi,
  output logic signed [W-1:0] y,
  output clp_e                st
);
  always_comb begin
    if (u > hi) begin
      y  = hi;
      st = CLP_HI;
    end else if (u < lo) begin
      y  = lo;
      st = CLP_LO;
    end else begin
      y  = u;
      st = CLP_NONE;
    end
  end
endmodule

// File: rtl/pi_regulator.sv
module pi_regulator
  import pi_reg_pkg::*;
#(
  parameter int unsigned W = Q_W,
  parameter int unsigned F = Q_F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic signed [W-1:0] in_pos,
  input  logic signed [W-1:0] in_neg,
  input  logic signed [W-1:0] kp,
  input  logic signed [W-1:0] ki,
  input  logic signed [W-1:0] dt,
  input  logic signed [W-1:0] lim_lo,
  input  logic signed [W-1:0] lim_hi,
  input  logic                aw_en,
  output logic signed [W-1:0] ctl_out,
  output logic                ctl_vld
);
  logic srst_n;

  pi_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // datapath
  logic signed [W-1:0] err, kidt, dint, pterm, acc, unl, lim_y, bc_hi, bc_lo;
  clp_e                lim_st;
  logic signed [W-1:0] integ_q, integ_d, y_q, y_d;
  logic                vld_q, vld_d;

  pi_satadd #(.W(W), .SUB(1'b1)) u_err  (.a(in_pos), .b(in_neg), .y(err));
  pi_qmul   #(.W(W), .F(F))      u_kidt (.a(ki),     .b(dt),     .y(kidt));
  pi_qmul   #(.W(W), .F(F))      u_dint (.a(kidt),   .b(err),    .y(dint));
  pi_qmul   #(.W(W), .F(F))      u_prop (.a(kp),     .b(err),    .y(pterm));
  pi_satadd #(.W(W), .SUB(1'b0)) u_acc  (.a(integ_q), .b(dint),  .y(acc));
  pi_satadd #(.W(W), .SUB(1'b0)) u_sum  (.a(pterm),  .b(acc),    .y(unl));
  pi_clamp  #(.W(W))             u_lim  (.u(unl), .lo(lim_lo), .hi(lim_hi),
                                         .y(lim_y), .st(lim_st));
  pi_satadd #(.W(W), .SUB(1'b1)) u_bchi (.a(lim_hi), .b(pterm),  .y(bc_hi));
  pi_satadd #(.W(W), .SUB(1'b1)) u_bclo (.a(lim_lo), .b(pterm),  .y(bc_lo));

  // next state
  always_comb begin
    integ_d = integ_q;
    y_d     = y_q;
    vld_d   = smp_vld;
    if (smp_vld) begin
      y_d = lim_y;
      if (aw_en && (lim_st == CLP_HI))      integ_d = bc_hi;
      else if (aw_en && (lim_st == CLP_LO)) integ_d = bc_lo;
      else                                  integ_d = acc;
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      integ_q <= '0;
      y_q     <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (smp_vld) begin
        integ_q <= integ_d;
        y_q     <= y_d;
      end
    end
  end

  assign ctl_out = y_q;
  assign ctl_vld = vld_q;

  // R2: valid follows the strobe by one clock
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!srst_n)
    smp_vld |=> ctl_vld);
  // R2: no valid without a strobe
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!srst_n)
    !smp_vld |=> !ctl_vld);
  // R10: idle cycles leave state and output untouched
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !smp_vld |=> ($stable(integ_q) && $stable(ctl_out)));
  // R5: a fresh output lies inside ordered limits
  a_r5_in_window: assert property (@(posedge clk) disable iff (!srst_n)
    (smp_vld && (lim_lo <= lim_hi)) |=>
      ((ctl_out <= $past(lim_hi)) && (ctl_out >= $past(lim_lo))));
  // R6: upper event with anti-windup lands the output on the upper limit
  a_r6_upper_hit: assert property (@(posedge clk) disable iff (!srst_n)
    (smp_vld && aw_en && (unl > lim_hi)) |=> (ctl_out == $past(lim_hi)));
endmodule

// File: tb/sim_pi_regulator.sv
module sim_pi_regulator;
  localparam int W = 24;
  localparam longint QMAX = 8388607;
  localparam longint QMIN = -8388608;
  localparam longint ONE  = 65536;

  logic clk, rst_n, smp_vld, aw_en;
  logic signed [W-1:0] in_pos, in_neg, kp, ki, dt, lim_lo, lim_hi;
  logic signed [W-1:0] ctl_out;
  logic ctl_vld;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;

  pi_regulator u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .in_pos(in_pos), .in_neg(in_neg),
    .kp(kp), .ki(ki), .dt(dt), .lim_lo(lim_lo), .lim_hi(lim_hi), .aw_en(aw_en),
    .ctl_out(ctl_out), .ctl_vld(ctl_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference
  function automatic longint sat(longint v);
    if (v > QMAX) return QMAX;
    if (v < QMIN) return QMIN;
    return v;
  endfunction
  function automatic longint qm(longint a, longint b);
    return sat((a * b) >>> 16);
  endfunction

  longint m_int = 0, m_y = 0;
  bit     m_v = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_int = 0; m_y = 0; m_v = 0;
    end else begin
      m_v = smp_vld;
      if (smp_vld) begin
        longint e, p, a, u, y, ni;
        e = sat(longint'(in_pos) - longint'(in_neg));
        p = qm(kp, e);
        a = sat(m_int + qm(qm(ki, dt), e));
        u = sat(p + a);
        if (u > lim_hi)      y = lim_hi;
        else if (u < lim_lo) y = lim_lo;
        else                 y = u;
        ni = a;
        if (aw_en && u > lim_hi)      ni = sat(longint'(lim_hi) - p);
        else if (aw_en && u < lim_lo) ni = sat(longint'(lim_lo) - p);
        m_int = ni; m_y = y;
      end
    end
  end

  // cycle-by-cycle comparison (R2, R5 and the rest through values)
  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (ctl_vld !== m_v) begin
        fails++;
        $display("FAIL R2 valid: actual=%0b expected=%0b at %0t", ctl_vld, m_v, $time);
      end
      checks++;
      if (longint'(ctl_out) != m_y) begin
        fails++;
        $display("FAIL R5 model compare: actual=%0d expected=%0d at %0t", ctl_out, m_y, $time);
      end
    end
  end

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0; smp_vld = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drive one strobe, return the registered result
  task automatic samp(longint p, longint n, output longint res);
    @(negedge clk); #1;
    in_pos = p; in_neg = n; smp_vld = 1'b1;
    @(negedge clk);
    res = ctl_out;
    #1 smp_vld = 1'b0;
  endtask

  task automatic setcfg(longint kp_v, longint ki_v, longint dt_v,
                        longint lo, longint hi, bit aw);
    kp = kp_v; ki = ki_v; dt = dt_v; lim_lo = lo; lim_hi = hi; aw_en = aw;
  endtask

  initial begin
    automatic longint r;
    rst_n = 1'b0; smp_vld = 1'b0; in_pos = '0; in_neg = '0;
    setcfg(0, 0, 0, QMIN, QMAX, 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out during reset", ctl_out, 0);
    chk("R1 valid during reset", ctl_vld, 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out after release", ctl_out, 0);
    cmp_on = 1;

    // R3: proportional only, 2.0 * (1.5 - 0.25) = 2.5
    setcfg(2 * ONE, 0, ONE, QMIN, QMAX, 1'b1);
    samp(98304, 16384, r);
    chk("R3 p-only", r, 163840);
    chk("R2 valid after strobe", ctl_vld, 1);
    @(negedge clk);
    chk("R2 valid drops", ctl_vld, 0);

    // R4: integral 1.0*0.5*1.0 per step
    do_reset();
    setcfg(0, ONE, ONE / 2, QMIN, QMAX, 1'b1);
    samp(ONE, 0, r); chk("R4 step1", r, 32768);
    samp(ONE, 0, r); chk("R4 step2", r, 65536);
    samp(ONE, 0, r); chk("R4 step3", r, 98304);

    // R10: idle cycles with wild inputs change nothing
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      in_pos = 24'(i * 77777); in_neg = 24'(-i * 3333); kp = 24'(i * 40000);
    end
    @(negedge clk);
    chk("R10 output held", ctl_out, 98304);
    samp(7 * ONE, 7 * ONE, r);
    chk("R10 integral held", r, 98304);

    // R6: anti-windup at upper limit, recovery
    do_reset();
    setcfg(ONE, ONE, ONE, -2 * ONE, 2 * ONE, 1'b1);
    samp(3 * ONE, 0, r); chk("R6 clamp hi", r, 2 * ONE);
    samp(3 * ONE, 0, r); chk("R6 clamp hi again", r, 2 * ONE);
    samp(0, ONE, r);     chk("R5 clamp lo", r, -2 * ONE);
    samp(0, 0, r);       chk("R6 back-calc recovery", r, -ONE);

    // R7: anti-windup at lower limit
    do_reset();
    setcfg(ONE, ONE, ONE, -2 * ONE, 2 * ONE, 1'b1);
    samp(0, 3 * ONE, r); chk("R7 clamp lo", r, -2 * ONE);
    samp(0, 0, r);       chk("R7 back-calc recovery", r, ONE);

    // R8: no anti-windup keeps the wound-up integral
    do_reset();
    setcfg(ONE, ONE, ONE, -2 * ONE, 2 * ONE, 1'b0);
    samp(3 * ONE, 0, r); chk("R8 clamp", r, 2 * ONE);
    samp(3 * ONE, 0, r); chk("R8 clamp", r, 2 * ONE);
    samp(0, 0, r);       chk("R8 stays limited", r, 2 * ONE);
    samp(0, ONE, r);     chk("R8 still limited", r, 2 * ONE);

    // R9: saturation
    do_reset();
    setcfg(100 * ONE, 0, ONE, QMIN, QMAX, 1'b1);
    samp(100 * ONE, 0, r); chk("R9 product sat", r, QMAX);
    setcfg(ONE, 0, ONE, QMIN, QMAX, 1'b1);
    samp(QMAX, QMIN, r);   chk("R9 error sat pos", r, QMAX);
    samp(QMIN, QMAX, r);   chk("R9 error sat neg", r, QMIN);

    // back-to-back strobes with varied settings, model-checked every cycle
    do_reset();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (i % 50 == 0) begin
        longint lo, hi;
        lo = -longint'($urandom_range(0, 6 * 65536));
        hi =  longint'($urandom_range(0, 6 * 65536));
        setcfg($urandom_range(0, 4 * 65536), $urandom_range(0, 3 * 65536),
               $urandom_range(0, 65536), lo, hi, 1'($urandom_range(0, 1)));
      end
      in_pos  = 24'(longint'($urandom_range(0, 8 * 65536)) - 4 * ONE);
      in_neg  = 24'(longint'($urandom_range(0, 8 * 65536)) - 4 * ONE);
      smp_vld = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk); #1 smp_vld = 1'b0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule